// File: doc/BRIEF.md
# Add/Subtract Accumulator with Run-Time Signedness and Overflow Flag

This block keeps a running total of width `W`. On every clock in which the enable is high, it adds the input word to the total or subtracts the input word from it. An operation select picks between add and subtract.

A signedness select sets how both the total and the input are read. When it is high, both are two's complement. When it is low, both are unsigned. The two operands never take different readings.

Alongside the total, the block drives a single flag for the update it just made. In unsigned mode the flag means carry-out when adding and borrow when subtracting. In two's complement mode it means the true result left the representable range. The total and the flag are registered on the same edge, so the flag always belongs to the value shown beside it.

Internally, both operands are widened by one bit, with zero extension or sign extension as the mode requires. The (W+1)-bit result then yields both the new total and the flag. The result wraps modulo 2^W and is not saturated.

Top module: `addsub_accum`

## Requirements
- R1: While `rst` is high at a rising clock edge, `acc` becomes 0 and `ovf` becomes 0 after that edge.
- R2: With `en`=1 and `add_sel`=1, after the edge `acc` equals (old `acc` + `din`) mod 2^W, in either signedness mode.
- R3: With `en`=1 and `add_sel`=0, after the edge `acc` equals (old `acc` - `din`) mod 2^W, in either signedness mode.
- R4: Unsigned add (`sgn_sel`=0, `add_sel`=1): `ovf` is 1 exactly when old `acc` + `din` ≥ 2^W. For example, all ones plus 1 gives 0 with `ovf`=1, and a following 0 plus 1 gives 1 with `ovf`=0.
- R5: Unsigned subtract (`sgn_sel`=0, `add_sel`=0): `ovf` is 1 exactly when `din` > old `acc`. Equal operands give `ovf`=0.
- R6: Signed add (`sgn_sel`=1, `add_sel`=1): `ovf` is 1 exactly when the true sum of the two's complement operands lies outside [-2^(W-1), 2^(W-1)-1]. Both positive overflow (0x7F+1 with W=8) and negative overflow are included.
- R7: Signed subtract (`sgn_sel`=1, `add_sel`=0): `ovf` is 1 exactly when the true difference lies outside the signed range. Subtracting the most negative code (0x80 with W=8) from any non-negative total sets `ovf`.
- R8: `acc` and `ovf` change together one edge after the enabled cycle. `ovf` describes only that update and returns to 0 on the next enabled update that does not overflow.
- R9: With `en`=0, `acc` and `ovf` keep their values regardless of `din`, `add_sel` and `sgn_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Update enable for this cycle |
| add_sel | input | 1 | 1 = add `din`, 0 = subtract `din` |
| sgn_sel | input | 1 | 1 = both operands two's complement, 0 = both unsigned |
| din | input | W | Input operand |
| acc | output | W | Registered running total |
| ovf | output | 1 | Registered carry, borrow or signed-overflow flag for the last update |

## Verification
The total is the block's only state, and it is fed back into every update. A wrong stored value therefore shows on `acc` one edge after the enabled cycle that produced it, and it spoils every later total until reset. A wrong extension or a wrong top-bit choice does not alter `acc`; it shows only on `ovf`, in the same cycle, and only at range boundaries. For that reason the stimulus drives each of the four mode combinations across its wrap point in both directions. It also covers equal operands and subtraction of the most negative code, and it compares `acc` and `ovf` after every single edge.

// File: rtl/addsub_accum_pkg.sv
package addsub_accum_pkg;

    typedef enum logic [1:0] {
        OP_UNS_ADD = 2'b00,
        OP_UNS_SUB = 2'b01,
        OP_SGN_ADD = 2'b10,
        OP_SGN_SUB = 2'b11
    } acc_op_e;

    function automatic acc_op_e decode_op(input logic sgn, input logic add);
        decode_op = acc_op_e'({sgn, ~add});
    endfunction

endpackage

// File: rtl/addsub_accum_ext.sv
module addsub_accum_ext #(
    parameter int W = 8
) (
    input  logic         sgn,
    input  logic [W-1:0] word,
    output logic [W:0]   wide
);
    // Copy the top bit upward only when the operand is two's complement.
    always_comb begin
        wide = {sgn & word[W-1], word};
    end
endmodule

// File: rtl/addsub_accum_core.sv
module addsub_accum_core #(
    parameter int W = 8
) (
    input  logic       add,
    input  logic [W:0] lhs,
    input  logic [W:0] rhs,
    output logic [W:0] res
);
    localparam int XW = W + 1;

    logic [XW-1:0] rhs_eff;
    logic          cin;

    // Subtraction is done as lhs + ~rhs + 1, so one adder serves both operations.
    always_comb begin
        rhs_eff = add ? rhs : ~rhs;
        cin     = ~add;
        res     = lhs + rhs_eff + {{(XW-1){1'b0}}, cin};
    end
endmodule

// File: rtl/addsub_accum_flag.sv
module addsub_accum_flag #(
    parameter int W = 8
) (
    input  addsub_accum_pkg::acc_op_e op,
    input  logic [W:0]                res,
    output logic                      flag
);
    import addsub_accum_pkg::*;

    logic top_mismatch;

    always_comb begin
        top_mismatch = res[W] ^ res[W-1];
        unique case (op)
            OP_UNS_ADD: flag = res[W];       // carry out of the low W bits
            OP_UNS_SUB: flag = res[W];       // wide difference negative means borrow
            OP_SGN_ADD,
            OP_SGN_SUB: flag = top_mismatch; // 01 positive, 10 negative overflow
            default:    flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/addsub_accum.sv
module addsub_accum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         add_sel,
    input  logic         sgn_sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] acc,
    output logic         ovf
);
    import addsub_accum_pkg::*;

    localparam int XW = W + 1;

    typedef struct packed {
        logic [W-1:0] total;
        logic         flag;
    } acc_state_t;

    acc_state_t state_d, state_q;
    acc_op_e    op;
    logic [XW-1:0] lhs_wide, rhs_wide, res_wide;
    logic          res_flag;

    assign op = decode_op(sgn_sel, add_sel);

    addsub_accum_ext #(.W(W)) u_ext_lhs (
        .sgn  (sgn_sel),
        .word (state_q.total),
        .wide (lhs_wide)
    );

    addsub_accum_ext #(.W(W)) u_ext_rhs (
        .sgn  (sgn_sel),
        .word (din),
        .wide (rhs_wide)
    );

    addsub_accum_core #(.W(W)) u_core (
        .add (add_sel),
        .lhs (lhs_wide),
        .rhs (rhs_wide),
        .res (res_wide)
    );

    addsub_accum_flag #(.W(W)) u_flag (
        .op   (op),
        .res  (res_wide),
        .flag (res_flag)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.total = '0;
            state_d.flag  = 1'b0;
        end else if (en) begin
            state_d.total = res_wide[W-1:0];
            state_d.flag  = res_flag;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign acc = state_q.total;
    assign ovf = state_q.flag;
endmodule

// File: rtl/addsub_accum_chk.sv
module addsub_accum_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         add_sel,
    input logic         sgn_sel,
    input logic [W-1:0] din,
    input logic [W-1:0] acc,
    input logic         ovf
);
    logic armed_q = 1'b0;

    always_ff @(posedge clk) begin
        armed_q <= armed_q | rst;
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        armed_q && $past(rst) |-> (acc == '0) && !ovf); // R1

    AST_ADD_VALUE: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(rst) && $past(en) && $past(add_sel)
        |-> acc == W'($past(acc) + $past(din))); // R2

    AST_SUB_VALUE: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(rst) && $past(en) && !$past(add_sel)
        |-> acc == W'($past(acc) - $past(din))); // R3

    AST_UNS_CARRY: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(rst) && $past(en) && $past(add_sel) && !$past(sgn_sel)
        |-> ovf == (acc < $past(acc))); // R4

    AST_UNS_BORROW: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(rst) && $past(en) && !$past(add_sel) && !$past(sgn_sel)
        |-> ovf == ($past(din) > $past(acc))); // R5

    AST_SGN_ADD_OVF: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(rst) && $past(en) && $past(add_sel) && $past(sgn_sel)
        |-> ovf == (($past(acc[W-1]) == $past(din[W-1])) && (acc[W-1] != $past(acc[W-1])))); // R6

    AST_SGN_SUB_OVF: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(rst) && $past(en) && !$past(add_sel) && $past(sgn_sel)
        |-> ovf == (($past(acc[W-1]) != $past(din[W-1])) && (acc[W-1] != $past(acc[W-1])))); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(rst) && !$past(en) |-> $stable(acc) && $stable(ovf)); // R9
endmodule

bind addsub_accum addsub_accum_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .add_sel (add_sel),
    .sgn_sel (sgn_sel),
    .din     (din),
    .acc     (acc),
    .ovf     (ovf)
);

// File: tb/addsub_accum_tb.sv
`timescale 1ns/1ps
module addsub_accum_tb;
    localparam int W    = 8;
    localparam int MODN = 1 << W;
    localparam int SMAX = (1 << (W-1)) - 1;
    localparam int SMIN = -(1 << (W-1));

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         add_sel = 1'b0;
    logic         sgn_sel = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] acc;
    logic         ovf;

    always #2.5 clk = ~clk;

    addsub_accum #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .add_sel(add_sel), .sgn_sel(sgn_sel),
        .din(din), .acc(acc), .ovf(ovf)
    );

    typedef struct {
        int    val;
        bit    flag;
        string vtag;
        string ftag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   model  = 0;
    bit   mflag  = 1'b0;
    bit   done   = 1'b0;

    function automatic int to_signed(int u);
        return (u > SMAX) ? u - MODN : u;
    endfunction

    // Driver: applies one cycle of stimulus and records what should follow it.
    task automatic step(bit r, bit e, bit a, bit s, int d, string vt, string ft);
        exp_t it;
        int   res;
        @(negedge clk);
        rst = r; en = e; add_sel = a; sgn_sel = s; din = W'(d);
        if (r) begin
            model = 0; mflag = 1'b0;
        end else if (e) begin
            if (!s) begin
                res   = a ? model + d : model - d;
                mflag = a ? (res >= MODN) : (d > model);
            end else begin
                res   = a ? to_signed(model) + to_signed(d) : to_signed(model) - to_signed(d);
                mflag = (res > SMAX) || (res < SMIN);
            end
            model = ((res % MODN) + MODN) % MODN;
        end
        it.val = model; it.flag = mflag; it.vtag = vt; it.ftag = ft;
        q.push_back(it);
    endtask

    // Monitor: compares the outputs shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                checks++;
                if (int'(acc) != it.val) begin
                    errors++;
                    $display("FAIL %s acc: actual %0h expected %0h", it.vtag, acc, it.val);
                end
                checks++;
                if (ovf != it.flag) begin
                    errors++;
                    $display("FAIL %s ovf: actual %0b expected %0b", it.ftag, ovf, it.flag);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        step(1, 0, 0, 0, 0, "R1", "R1");
        step(1, 1, 1, 1, 8'h55, "R1", "R1");
        // unsigned add across the wrap point
        step(0, 1, 1, 0, 8'hFF, "R2", "R4");
        step(0, 1, 1, 0, 8'h01, "R2", "R4");
        step(0, 1, 1, 0, 8'h01, "R2", "R8");
        // enable low: nothing moves
        step(0, 0, 1, 0, 8'hFF, "R9", "R9");
        step(0, 0, 0, 1, 8'h80, "R9", "R9");
        // unsigned subtract: borrow, no borrow, equal operands
        step(0, 1, 0, 0, 8'h02, "R3", "R5");
        step(0, 1, 0, 0, 8'h0F, "R3", "R5");
        step(0, 1, 0, 0, 8'hF0, "R3", "R5");
        step(1, 0, 0, 0, 0, "R1", "R1");
        // signed add: positive overflow then clear
        step(0, 1, 1, 1, 8'h7F, "R2", "R6");
        step(0, 1, 1, 1, 8'h01, "R2", "R6");
        step(0, 1, 1, 1, 8'h01, "R2", "R8");
        // signed subtract: negative limit crossing and most-negative input
        step(0, 1, 0, 1, 8'h01, "R3", "R7");
        step(0, 1, 0, 1, 8'h01, "R3", "R7");
        step(0, 1, 0, 1, 8'h7F, "R3", "R7");
        step(0, 1, 0, 1, 8'h80, "R3", "R7");
        step(0, 1, 0, 1, 8'h80, "R3", "R7");
        step(0, 1, 0, 1, 8'hFF, "R3", "R7");
        // signed add: negative overflow
        step(0, 1, 1, 1, 8'h80, "R2", "R6");
        step(0, 1, 1, 1, 8'h80, "R2", "R6");
        step(0, 0, 1, 1, 8'h80, "R9", "R9");
        // mixed pseudorandom traffic
        for (int i = 0; i < 300; i++) begin
            bit e, a, s;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            e = (lfsr[3:0] != 4'h0);
            a = lfsr[5];
            s = lfsr[7];
            step(0, e, a, s, int'(lfsr[15:8]),
                 !e ? "R9" : (a ? "R2" : "R3"),
                 !e ? "R9" : (s ? (a ? "R6" : "R7") : (a ? "R4" : "R5")));
        end
        step(0, 0, 0, 0, 0, "R9", "R9");
        wait (q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule